// File: doc/BRIEF.md
# Serial Port Bit-Clock Router

This block chooses where the bit clocks of a synchronous serial port come from, and it drives the port's transmit data pin. It runs entirely in the core clock domain.

An internal bit clock is built by a programmable divider. An external clock arriving on a pin is brought into the core domain by a two-flop synchronizer. Either source is reduced to single-cycle rise and fall strobes. In synchronous mode a single clock pin times both directions. In asynchronous mode the main clock pin times the transmitter and an auxiliary clock pin times the receiver. Per-direction selects decide whether each clock pin is an input or carries the internal clock outward.

The transmit side holds one word in a buffer behind a valid/ready handshake and shifts it out MSB first. It keeps the data pin driven across back-to-back words. When it runs on the internal clock and no word follows, it releases the pin for a bit period. The receive side assembles words MSB first.

Top module: `sspr_clock_router`

## Requirements
- R1: With `sync_mode`=1, both transmitter and receiver are timed by the main clock (internal when `tx_clk_int`=1, else `serclk_in`), `rx_clk_int` has no effect, and `auxclk_oe` is 0.
- R2: With `sync_mode`=0, the receiver is timed only by the auxiliary clock: `rx_clk_int`=1 drives the internal clock on `auxclk_out` with `auxclk_oe`=1 and uses it; `rx_clk_int`=0 takes `auxclk_in` as input, and activity on the main clock does not clock the receiver.
- R3: `tx_clk_int`=1 drives the internal bit clock on `serclk_out` with `serclk_oe`=1; `tx_clk_int`=0 sets `serclk_oe`=0 and times the transmitter from `serclk_in`.
- R4: The internal bit clock stays high for `div_half` core cycles and low for `div_half` core cycles; any `div_half` below 2 acts as 2, so the ratio is never below 4.
- R5: External clock pins pass through a two-flop synchronizer; a pin edge becomes a strobe two core cycles later, and data is still shifted correctly with an external clock whose phases each last 5 core cycles.
- R6: Transmit data leaves MSB first; `txd_out` changes only in the cycle after a bit-clock rise and is stable while the internal bit clock is low.
- R7: The receiver samples `rxd_in` on bit-clock falls, MSB first, once `rx_enable`=1 (0 clears the bit count); after `WORD_W` samples `rx_data` holds the word and `rx_valid` pulses for exactly one cycle.
- R8: `tx_ready` is 1 exactly while the one-word buffer is empty; a word accepted while the transmitter is idle begins at the first bit-clock rise after acceptance.
- R9: A word accepted before the rise that ends the current word's last bit period follows without a gap, and `txd_oe` stays 1 in every cycle between the two words.
- R10: With the internal transmit clock and no word waiting, `txd_oe` drops to 0 at the rise that ends the last bit, and stays 0 for that whole bit period.
- R11: With the external transmit clock, `txd_oe` stays 1 after the last bit of a word when no word follows.
- R12: During reset `txd_oe`=0, `tx_ready`=1, `rx_valid`=0 and `serclk_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: one shared clock; 0: separate receive clock |
| tx_clk_int | input | 1 | 1: internal clock driven on main clock pin |
| rx_clk_int | input | 1 | 1: internal clock driven on auxiliary pin (asynchronous mode) |
| div_half | input | DIV_W | Internal bit-clock half period in core cycles |
| serclk_in | input | 1 | Main clock pin, input side |
| serclk_out | output | 1 | Main clock pin, output side |
| serclk_oe | output | 1 | Main clock pin output enable |
| auxclk_in | input | 1 | Auxiliary clock pin, input side |
| auxclk_out | output | 1 | Auxiliary clock pin, output side |
| auxclk_oe | output | 1 | Auxiliary clock pin output enable |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty |
| txd_out | output | 1 | Transmit data pin value |
| txd_oe | output | 1 | Transmit data pin output enable |
| rx_enable | input | 1 | Receiver enable; 0 clears bit count |
| rxd_in | input | 1 | Receive data pin |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse on new word |

## Verification
Pin directions follow the mode inputs in the same cycle and are checked one step after the inputs change. With the internal clock, the divider registers the bit-clock level and its strobe on the same edge. The shifters act on the next edge, so transmit data moves one core cycle after the clock pin rises, and receive data is captured one cycle after the clock pin falls. External pins pass through two synchronizer stages before they produce a strobe. The bench therefore follows each external clock through its own two-stage delay before counting edges. It reads the data pin and its enable at each counted fall, by which point every shift for that bit has settled. Receive results are read one bit-clock rise after the last fall.

// File: rtl/sspr_pkg.sv
package sspr_pkg;
  // single-cycle strobes marking bit-clock transitions in the core domain
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_stb_t;
endpackage

// File: rtl/sspr_bitclk_div.sv
module sspr_bitclk_div
  import sspr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_i,
  output logic             bclk_o,
  output edge_stb_t        stb_o
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] eff_half;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  edge_stb_t        stb_q, stb_d;
  logic             wrap;

  always_comb begin
    eff_half   = (half_i < MIN_HALF) ? MIN_HALF : half_i;
    wrap       = (cnt_q >= eff_half - ONE);
    cnt_d      = wrap ? '0 : cnt_q + ONE;
    bclk_d     = wrap ? ~bclk_q : bclk_q;
    stb_d.rise = wrap & ~bclk_q;
    stb_d.fall = wrap & bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
      stb_q  <= stb_d;
    end
  end

  assign bclk_o = bclk_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/sspr_edge_sync.sv
module sspr_edge_sync
  import sspr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  output edge_stb_t stb_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // compare the last synchronized stage with the one behind it
  assign stb_o.rise = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign stb_o.fall = ~sh_q[SH_W-2] & sh_q[SH_W-1];
endmodule

// File: rtl/sspr_tx_shift.sv
module sspr_tx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              int_clk_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              oe_o
);
  localparam int              CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic              hvld_q, hvld_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              oe_q, oe_d;
  logic              accept;
  logic              hold_en, shift_en;

  always_comb begin
    hold_d   = hold_q;
    hvld_d   = hvld_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    act_d    = act_q;
    oe_d     = oe_q;
    accept   = valid_i & ~hvld_q;
    hold_en  = accept;
    shift_en = rise_i;
    if (accept) begin
      hold_d = data_i;
      hvld_d = 1'b1;
    end
    if (rise_i) begin
      if (act_q && (cnt_q != LAST)) begin
        sh_d  = {sh_q[WORD_W-2:0], 1'b0};
        cnt_d = cnt_q + ONE;
      end else if (hvld_q) begin
        // idle start, or the follower of a back-to-back pair
        sh_d   = hold_q;
        cnt_d  = '0;
        act_d  = 1'b1;
        oe_d   = 1'b1;
        hvld_d = 1'b0;
      end else if (act_q) begin
        act_d = 1'b0;
        if (int_clk_i) oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hvld_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      hvld_q <= hvld_d;
      if (shift_en) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
        act_q <= act_d;
        oe_q  <= oe_d;
      end
    end
  end

  assign ready_o = ~hvld_q;
  assign txd_o   = sh_q[WORD_W-1];
  assign oe_o    = oe_q;
endmodule

// File: rtl/sspr_rx_shift.sv
module sspr_rx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              enable_i,
  input  logic              rxd_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  localparam int              CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic              dat_en;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    dat_d  = {sh_q[WORD_W-2:0], rxd_i};
    dat_en = 1'b0;
    vld_d  = 1'b0;
    if (!enable_i) begin
      cnt_d = '0;
    end else if (fall_i) begin
      sh_d = {sh_q[WORD_W-2:0], rxd_i};
      if (cnt_q == LAST) begin
        dat_en = 1'b1;
        vld_d  = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assign data_o  = dat_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/sspr_clock_router.sv
module sspr_clock_router
  import sspr_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int DIV_W    = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              tx_clk_int,
  input  logic              rx_clk_int,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              serclk_in,
  output logic              serclk_out,
  output logic              serclk_oe,
  input  logic              auxclk_in,
  output logic              auxclk_out,
  output logic              auxclk_oe,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd_out,
  output logic              txd_oe,
  input  logic              rx_enable,
  input  logic              rxd_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int N_EXT = 2;  // index 0: main pin, 1: auxiliary pin

  logic [1:0] rs_q;
  logic       rst_core_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic      int_bclk;
  edge_stb_t int_stb;
  edge_stb_t ext_stb [N_EXT];
  logic      ext_pin [N_EXT];
  edge_stb_t tx_stb, rx_stb;

  assign ext_pin[0] = serclk_in;
  assign ext_pin[1] = auxclk_in;

  sspr_bitclk_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .half_i (div_half),
    .bclk_o (int_bclk),
    .stb_o  (int_stb)
  );

  for (genvar gi = 0; gi < N_EXT; gi++) begin : g_ext
    sspr_edge_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_core_n),
      .pin_i (ext_pin[gi]),
      .stb_o (ext_stb[gi])
    );
  end

  always_comb begin
    tx_stb = tx_clk_int ? int_stb : ext_stb[0];
    if (sync_mode)       rx_stb = tx_stb;
    else if (rx_clk_int) rx_stb = int_stb;
    else                 rx_stb = ext_stb[1];
  end

  assign serclk_oe  = tx_clk_int;
  assign serclk_out = tx_clk_int & int_bclk;
  assign auxclk_oe  = ~sync_mode & rx_clk_int;
  assign auxclk_out = auxclk_oe & int_bclk;

  sspr_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rise_i    (tx_stb.rise),
    .int_clk_i (tx_clk_int),
    .data_i    (tx_data),
    .valid_i   (tx_valid),
    .ready_o   (tx_ready),
    .txd_o     (txd_out),
    .oe_o      (txd_oe)
  );

  sspr_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fall_i   (rx_stb.fall),
    .enable_i (rx_enable),
    .rxd_i    (rxd_in),
    .data_o   (rx_data),
    .valid_o  (rx_valid)
  );
endmodule

// File: rtl/sspr_clock_router_chk.sv
module sspr_clock_router_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_clk_int,
  input logic serclk_out,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd_out,
  input logic txd_oe,
  input logic rx_valid
);
  // R8: an accepted word fills the buffer
  p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  // R9: the buffer only empties by handing its word to a driving shifter
  p_ready_with_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> txd_oe);

  // R10 / R11: the data pin is released only under the internal clock
  p_release_internal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_oe) |-> $past(tx_clk_int));

  // R6: no data movement while the internal bit clock is low
  p_data_still_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk_int && !serclk_out |=> $stable(txd_out));

  // R7: the word-valid strobe never lasts two cycles
  p_rx_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind sspr_clock_router sspr_clock_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_clk_int (tx_clk_int),
  .serclk_out (serclk_out),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .txd_out    (txd_out),
  .txd_oe     (txd_oe),
  .rx_valid   (rx_valid)
);

// File: tb/sim_sspr_clock_router.sv
`timescale 1ns/1ps
module sim_sspr_clock_router;
  localparam int W     = 8;
  localparam int DW    = 8;
  localparam int EXT_H = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sync_mode, tx_clk_int, rx_clk_int;
  logic [DW-1:0] div_half;
  logic          serclk_in, auxclk_in;
  logic          serclk_out, serclk_oe, auxclk_out, auxclk_oe;
  logic [W-1:0]  tx_data;
  logic          tx_valid, tx_ready, txd_out, txd_oe;
  logic          rx_enable, rxd_in;
  logic [W-1:0]  rx_data;
  logic          rx_valid;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sspr_clock_router #(.WORD_W(W), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tx_clk_int(tx_clk_int),
    .rx_clk_int(rx_clk_int), .div_half(div_half), .serclk_in(serclk_in),
    .serclk_out(serclk_out), .serclk_oe(serclk_oe), .auxclk_in(auxclk_in),
    .auxclk_out(auxclk_out), .auxclk_oe(auxclk_oe), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd_out(txd_out), .txd_oe(txd_oe),
    .rx_enable(rx_enable), .rxd_in(rxd_in), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  function automatic int eff_half(input int h);
    return (h < 2) ? 2 : h;
  endfunction

  // external clock sources, moved just after the falling core edge
  bit run_ser = 0, run_aux = 0;
  initial begin
    int ph = 0;
    serclk_in = 1'b0;
    auxclk_in = 1'b0;
    forever begin
      @(negedge clk); #1;
      ph++;
      if (ph == EXT_H) begin
        ph = 0;
        if (run_ser) serclk_in = ~serclk_in;
        if (run_aux) auxclk_in = ~auxclk_in;
      end
    end
  end

  // bench view of external pins after two core-clock stages
  logic [1:0] d_ser = 2'b00, d_aux = 2'b00;
  always @(posedge clk) begin
    d_ser <= {d_ser[0], serclk_in};
    d_aux <= {d_aux[0], auxclk_in};
  end

  // edge monitor: 0 main out, 1 main in (delayed), 2 aux out, 3 aux in (delayed)
  int sel = 0;
  int rise_cnt = 0, cyc = 0, last_rise = 0, period = 0;
  int rx_cnt = 0, oe_low = 0;
  logic [W-1:0] rx_last = '0;
  bit mon_prev = 0;
  bit samp_d [512];
  bit samp_oe[512];
  always @(negedge clk) begin
    bit now;
    case (sel)
      0: now = serclk_out;
      1: now = d_ser[1];
      2: now = auxclk_out;
      default: now = d_aux[1];
    endcase
    cyc++;
    if (now && !mon_prev) begin
      rise_cnt++;
      period = cyc - last_rise;
      last_rise = cyc;
    end
    if (!now && mon_prev) begin
      samp_d[rise_cnt & 511]  = txd_out;
      samp_oe[rise_cnt & 511] = txd_oe;
    end
    mon_prev = now;
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
    end
    if (!txd_oe) oe_low++;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_rises(input int n);
    int t = rise_cnt + n;
    while (rise_cnt < t) step();
  endtask

  function automatic logic [W-1:0] gather(input int first);
    logic [W-1:0] v;
    for (int k = 0; k < W; k++) v[W-1-k] = samp_d[(first + k) & 511];
    return v;
  endfunction

  function automatic bit all_driven(input int first, input int n);
    for (int k = 0; k < n; k++) if (!samp_oe[(first + k) & 511]) return 0;
    return 1;
  endfunction

  // send one word, or two back to back, and check the pin stream
  task automatic run_tx(input logic [W-1:0] w0, input logic [W-1:0] w1, input bit two);
    int r0, n;
    logic [W-1:0] got;
    step();
    chk(tx_ready == 1'b1, "R8 ready while idle", tx_ready, 1);
    r0 = rise_cnt;
    tx_data  = w0;
    tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
    if (two) begin
      while (!tx_ready) step();
      tx_data  = w1;
      tx_valid = 1'b1;
      step();
      tx_valid = 1'b0;
    end
    n = two ? 2 * W : W;
    wait_rises(r0 + 2 - rise_cnt);
    oe_low = 0;
    wait_rises(r0 + n + 1 - rise_cnt);
    if (two) chk(oe_low == 0, "R9 no release between words", oe_low, 0);
    wait_rises(r0 + n + 2 - rise_cnt);
    got = gather(r0 + 1);
    chk(got == w0, "R6 word MSB first", got, w0);
    if (two) begin
      got = gather(r0 + 1 + W);
      chk(got == w1, "R9 follower word", got, w1);
    end
    chk(all_driven(r0 + 1, n), "R9 driven during bits", 0, 1);
    if (tx_clk_int)
      chk(samp_oe[(r0 + n + 1) & 511] == 1'b0, "R10 release after last bit",
          samp_oe[(r0 + n + 1) & 511], 0);
    else
      chk(samp_oe[(r0 + n + 1) & 511] == 1'b1, "R11 held with external clock",
          samp_oe[(r0 + n + 1) & 511], 1);
  endtask

  task automatic run_rx(input logic [W-1:0] w, input string req);
    int c0, b;
    rx_enable = 1'b0;
    step();
    wait_rises(1);
    rx_enable = 1'b1;
    rxd_in    = w[W-1];
    c0 = rx_cnt;
    for (int k = 1; k < W; k++) begin
      wait_rises(1);
      rxd_in = w[W-1-k];
    end
    wait_rises(2);
    chk(rx_cnt == c0 + 1, {req, " one word pulse"}, rx_cnt - c0, 1);
    chk(rx_last == w, {req, " received word"}, rx_last, w);
    rx_enable = 1'b0;
    b = 0;
  endtask

  task automatic set_mode(input bit s, input bit ti, input bit ri, input int msel);
    sync_mode  = s;
    tx_clk_int = ti;
    rx_clk_int = ri;
    sel        = msel;
    wait_rises(3);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd777);
    rst_n = 1'b0;
    sync_mode = 1'b0; tx_clk_int = 1'b1; rx_clk_int = 1'b0;
    div_half = 8'd3; tx_data = '0; tx_valid = 1'b0;
    rx_enable = 1'b0; rxd_in = 1'b0;
    repeat (4) step();
    // R12: reset state
    chk(txd_oe == 1'b0, "R12 txd_oe in reset", txd_oe, 0);
    chk(tx_ready == 1'b1, "R12 tx_ready in reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R12 rx_valid in reset", rx_valid, 0);
    chk(serclk_out == 1'b0, "R12 clock low in reset", serclk_out, 0);
    rst_n = 1'b1;
    repeat (6) step();

    // R1 / R2 / R3: pin directions for every mode combination
    for (int m = 0; m < 8; m++) begin
      sync_mode = m[2]; tx_clk_int = m[1]; rx_clk_int = m[0];
      #1;
      chk(serclk_oe == m[1], "R3 main pin direction", serclk_oe, m[1]);
      chk(auxclk_oe == (!m[2] && m[0]), "R1 R2 aux pin direction", auxclk_oe,
          (!m[2] && m[0]));
    end

    // R4: internal divider, including clamped settings
    run_ser = 1;
    foreach (div_half_set[i]) ;
    for (int i = 0; i < 5; i++) begin
      int h;
      h = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 2 : (i == 3) ? 3 : 7;
      div_half = DW'(h);
      set_mode(1'b0, 1'b1, 1'b1, 0);
      chk(period == 2 * eff_half(h), "R4 bit-clock period", period, 2 * eff_half(h));
    end

    // R6 / R8 / R10 / R9: directed internal-clock words
    div_half = 8'd2;
    set_mode(1'b0, 1'b1, 1'b1, 0);
    run_tx(8'hA5, 8'h00, 1'b0);
    run_tx(8'h81, 8'h7E, 1'b1);

    // R5 / R11: external transmit clock
    set_mode(1'b0, 1'b0, 1'b1, 1);
    run_tx(8'h3C, 8'h00, 1'b0);
    run_tx(8'hF0, 8'h0F, 1'b1);

    // random words, clock sources and divider settings
    for (int i = 0; i < 10; i++) begin
      bit ext, two;
      ext = ($urandom % 3) == 0;
      two = $urandom % 2;
      div_half = DW'($urandom % 6);
      set_mode(1'b0, !ext, 1'b1, ext ? 1 : 0);
      run_tx(W'($urandom), W'($urandom), two);
    end

    // R1: shared clock in synchronous mode, receive select ignored
    div_half = 8'd3;
    set_mode(1'b1, 1'b1, 1'b0, 0);
    run_rx(8'hC6, "R1 R7 sync internal");
    // R2: receiver on auxiliary pin driven internally
    set_mode(1'b0, 1'b1, 1'b1, 2);
    run_rx(8'h5B, "R2 R7 aux internal");
    // R2 / R5: receiver on external auxiliary clock
    run_aux = 1;
    set_mode(1'b0, 1'b1, 1'b0, 3);
    run_rx(8'h93, "R2 R5 aux external");
    // R2: a running main clock does not clock the receiver
    run_aux = 0;
    begin
      int c0;
      set_mode(1'b0, 1'b1, 1'b0, 0);
      c0 = rx_cnt;
      rx_enable = 1'b1;
      rxd_in = 1'b1;
      repeat (80) step();
      chk(rx_cnt == c0, "R2 receiver ignores main clock", rx_cnt - c0, 0);
      rx_enable = 1'b0;
    end

    done = 1;
    summary();
    $finish;
  end

  int div_half_set[1];

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule